// File: doc/BRIEF.md
# Shuffled Loop Index Generator

This block supplies the loop indices for one pass of a transform stage or an elementwise pass, and it does so in a randomized order. A plain up-counter would expose which coefficient is handled at which moment. Here the order comes from a Galois linear feedback shift register over a primitive polynomial. The register is loaded from a caller-supplied random seed at the start of every pass. Index zero is always issued first, because the register can never reach the all-zero state. The register then walks through every nonzero index exactly once. The seed source and the datapath that consumes the indices sit outside this block.

A pass begins when `start` is pulsed while the generator is idle. The `mode` input picks the index width for that pass. For a ring of 2^N_LOG2 coefficients, mode 0 serves the butterfly loop of a transform stage with N_LOG2−1 index bits, and mode 1 serves a full elementwise loop with N_LOG2 index bits. The consumer takes each index by pulsing `advance`. The index in use is held until that strobe and is replaced one cycle later. `last` marks the final index of the pass, and an `advance` taken on it returns the block to idle.

Top module: `idx_shuffle_gen`

## Requirements
- R1: After reset, `index_valid` is 0, `last` is 0 and `index` is 0.
- R2: A `start` pulse while idle sets `index_valid` to 1 in the next cycle, with `index` equal to 0 and `last` equal to 0.
- R3: While `index_valid` is 1 and `advance` is 0, `index`, `index_valid` and `last` keep their values. An `advance` while valid updates them in the following cycle.
- R4: With `mode`=0, each pass issues 2^(N_LOG2−1) indices (128 by default), and the top bit of `index` stays 0. Each index after the second is the previous index multiplied by x modulo x^7+x^6+1: shift left by one within 7 bits, and if the old bit 6 was 1, XOR with 0x41.
- R5: With `mode`=1, each pass issues 2^N_LOG2 indices (256 by default). Each index after the second is the previous index multiplied by x modulo x^8+x^6+x^5+x^4+1: shift left by one within 8 bits, and if the old bit 7 was 1, XOR with 0x71.
- R6: The second index of a pass is the seed sampled at `start`. In mode 0 only seed bits 6..0 are used and seed bit 7 is ignored. If the used seed bits are all zero, the second index is 1.
- R7: Within one pass, every nonzero value of the selected width appears exactly once as an index.
- R8: `last` is 1 exactly while the final index of the pass is shown. An `advance` taken on that index drives `index_valid` to 0 in the next cycle.
- R9: A `start` while a pass is running is ignored: the index, the pass length and the order of the pass are unchanged.
- R10: An `advance` while idle is ignored: `index_valid` and `last` stay 0, and the next pass still begins with 0 followed by its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a pass when idle |
| seed | input | N_LOG2 | Random seed sampled at start |
| mode | input | 1 | 0 = transform-stage loop, 1 = elementwise loop |
| advance | input | 1 | Consumer takes the current index |
| index | output | N_LOG2 | Current loop index |
| index_valid | output | 1 | A pass is running and index is meaningful |
| last | output | 1 | Current index is the final one of the pass |

## Verification
A corrupted shift-register state appears at the ports no later than the next `advance`: the emitted index departs from the multiply-by-x sequence, and the sequence soon repeats a value or skips one, which breaks the one-visit property. A wrong pass counter moves `last` away from the 2^k-th index, so a pass ends early or late, and this is detected within that same pass. A latched mode that has the wrong value shows up at once as a top index bit set in mode 0, or as a pass of the wrong length.

// File: rtl/idx_shuffle_pkg.sv
package idx_shuffle_pkg;
   typedef enum logic {
      PASS_STAGE = 1'b0,
      PASS_ELEM  = 1'b1
   } pass_mode_e;
endpackage

// File: rtl/idx_lfsr_step.sv
// One Galois step: multiply the state by x modulo the polynomial whose
// lower coefficients are POLY (the leading term is implicit).
module idx_lfsr_step #(
   parameter int             W    = 8,
   parameter logic [W-1:0]   POLY = 8'h71
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   logic fb;
   assign fb = cur[W-1];

   for (genvar gi = 0; gi < W; gi++) begin : g_bit
      if (gi == 0) begin : g_lsb
         assign nxt[gi] = POLY[gi] & fb;
      end else begin : g_up
         assign nxt[gi] = cur[gi-1] ^ (POLY[gi] & fb);
      end
   end
endmodule

// File: rtl/idx_pass_ctrl.sv
// Pass sequencing: busy flag, position counter, final-index detection.
module idx_pass_ctrl #(
   parameter int N_LOG2 = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic advance,
   input  logic wide_q,
   output logic busy,
   output logic load,
   output logic step,
   output logic at_end
);
   localparam int CW = N_LOG2;
   localparam logic [CW-1:0] LIM_WIDE   = {CW{1'b1}};
   localparam logic [CW-1:0] LIM_NARROW = {1'b0, {(CW-1){1'b1}}};

   logic          busy_q;
   logic [CW-1:0] pos_q;
   logic [CW-1:0] limit;

   assign limit  = wide_q ? LIM_WIDE : LIM_NARROW;
   assign busy   = busy_q;
   assign load   = start & ~busy_q;
   assign step   = advance & busy_q;
   assign at_end = busy_q & (pos_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pos_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         pos_q  <= '0;
      end else if (step) begin
         if (at_end) begin
            busy_q <= 1'b0;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/idx_shuffle_gen.sv
module idx_shuffle_gen
   import idx_shuffle_pkg::*;
#(
   parameter int                  N_LOG2     = 8,
   parameter logic [N_LOG2-2:0]   POLY_STAGE = 7'h41,
   parameter logic [N_LOG2-1:0]   POLY_ELEM  = 8'h71
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [N_LOG2-1:0] seed,
   input  logic              mode,
   input  logic              advance,
   output logic [N_LOG2-1:0] index,
   output logic              index_valid,
   output logic              last
);
   localparam int KS = N_LOG2 - 1;
   localparam int KE = N_LOG2;

   if (N_LOG2 < 3 || N_LOG2 > 16) begin : g_bad_width
      $error("idx_shuffle_gen: N_LOG2 out of range");
   end
   if (POLY_STAGE[0] != 1'b1 || POLY_ELEM[0] != 1'b1) begin : g_bad_poly
      $error("idx_shuffle_gen: polynomial must have a constant term");
   end

   pass_mode_e        mode_q;
   logic [KE-1:0]     lfsr_q;
   logic [KE-1:0]     index_q;
   logic [KE-1:0]     seed_used;
   logic [KE-1:0]     seed_fix;
   logic [KS-1:0]     nxt_stage;
   logic [KE-1:0]     nxt_elem;
   logic [KE-1:0]     lfsr_next;
   logic              busy, load, step, at_end;
   pass_mode_e        mode_in;

   assign mode_in   = pass_mode_e'(mode);
   assign seed_used = (mode_in == PASS_ELEM) ? seed : {1'b0, seed[KS-1:0]};
   assign seed_fix  = (seed_used == '0) ? {{(KE-1){1'b0}}, 1'b1} : seed_used;

   idx_lfsr_step #(.W(KS), .POLY(POLY_STAGE)) u_step_stage (
      .cur (lfsr_q[KS-1:0]),
      .nxt (nxt_stage)
   );

   idx_lfsr_step #(.W(KE), .POLY(POLY_ELEM)) u_step_elem (
      .cur (lfsr_q),
      .nxt (nxt_elem)
   );

   assign lfsr_next = (mode_q == PASS_ELEM) ? nxt_elem : {1'b0, nxt_stage};

   idx_pass_ctrl #(.N_LOG2(N_LOG2)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .advance (advance),
      .wide_q  (mode_q == PASS_ELEM),
      .busy    (busy),
      .load    (load),
      .step    (step),
      .at_end  (at_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= PASS_STAGE;
         lfsr_q  <= {{(KE-1){1'b0}}, 1'b1};
         index_q <= '0;
      end else if (load) begin
         mode_q  <= mode_in;
         lfsr_q  <= seed_fix;
         index_q <= '0;
      end else if (step && !at_end) begin
         index_q <= lfsr_q;
         lfsr_q  <= lfsr_next;
      end
   end

   assign index       = index_q;
   assign index_valid = busy;
   assign last        = at_end;
endmodule

// File: rtl/idx_shuffle_chk.sv
module idx_shuffle_chk #(
   parameter int N_LOG2 = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              advance,
   input logic              mode_q,
   input logic [N_LOG2-1:0] index,
   input logic              index_valid,
   input logic              last
);
   AST_IDLE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      !index_valid |-> !last); // R8

   AST_PASS_OPENS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!index_valid && start) |=> (index_valid && index == '0 && !last)); // R2

   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (index_valid && !advance) |=> (index_valid && $stable(index) && $stable(last))); // R3

   AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (index_valid && advance && !last) |=> (index_valid && index != '0)); // R7

   AST_PASS_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (index_valid && advance && last) |=> !index_valid); // R8

   AST_STAGE_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (index_valid && !mode_q) |-> !index[N_LOG2-1]); // R4

   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!index_valid && !start) |=> !index_valid); // R10
endmodule

bind idx_shuffle_gen idx_shuffle_chk #(.N_LOG2(N_LOG2)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .advance     (advance),
   .mode_q      (mode_q),
   .index       (index),
   .index_valid (index_valid),
   .last        (last)
);

// File: tb/idx_shuffle_gen_bench.sv
module idx_shuffle_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] seed = '0;
   logic       mode = 1'b0;
   logic       advance = 1'b0;
   logic [7:0] index;
   logic       index_valid;
   logic       last;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   idx_shuffle_gen u_idx_shuffle_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .mode(mode),
      .advance(advance), .index(index), .index_valid(index_valid), .last(last)
   );

   function automatic logic [7:0] mul_x(input logic [7:0] v, input logic m);
      logic [7:0] r;
      if (m) begin
         r = {v[6:0], 1'b0};
         if (v[7]) r = r ^ 8'h71;
      end else begin
         r = {1'b0, v[5:0], 1'b0};
         if (v[6]) r = r ^ 8'h41;
      end
      return r;
   endfunction

   function automatic logic [7:0] seed_rule(input logic [7:0] s, input logic m);
      logic [7:0] u;
      u = m ? s : {1'b0, s[6:0]};
      return (u == 8'h00) ? 8'h01 : u;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick();
      check("R1 valid", index_valid, 0);
      check("R1 last", last, 0);
      check("R1 index", index, 0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_full_pass(input logic m, input logic [7:0] s);
      bit seen[256];
      int len;
      logic [7:0] exp;
      len = m ? 256 : 128;
      foreach (seen[k]) seen[k] = 1'b0;
      start = 1'b1; seed = s; mode = m;
      tick();
      start = 1'b0; seed = 8'hFF; mode = ~m;
      check("R2 valid", index_valid, 1);
      check("R2 index", index, 0);
      check("R2 last", last, 0);
      exp = seed_rule(s, m);
      for (int i = 1; i < len; i++) begin
         advance = 1'b1;
         tick();
         advance = 1'b0;
         if (i == 1) check("R6 second index is seed", index, exp);
         else check(m ? "R5 sequence" : "R4 sequence", index, exp);
         check("R8 last position", last, (i == len - 1));
         if (!m) check("R4 top bit", index[7], 0);
         check("R7 unique", seen[index], 0);
         seen[index] = 1'b1;
         if (i % 37 == 0) begin
            tick();
            check("R3 hold index", index, exp);
            check("R3 hold valid", index_valid, 1);
         end
         exp = mul_x(exp, m);
      end
      advance = 1'b1;
      tick();
      advance = 1'b0;
      check("R8 pass ends", index_valid, 0);
      check("R8 last clears", last, 0);
   endtask

   task automatic t_start_busy();
      int cnt;
      start = 1'b1; seed = 8'h03; mode = 1'b1;
      tick();
      start = 1'b0;
      advance = 1'b1; tick();
      advance = 1'b1; tick();
      advance = 1'b0;
      check("R9 pre index", index, 8'h06);
      start = 1'b1; seed = 8'h55; mode = 1'b0;
      tick();
      start = 1'b0;
      check("R9 index kept", index, 8'h06);
      check("R9 valid kept", index_valid, 1);
      advance = 1'b1; tick(); advance = 1'b0;
      check("R9 order kept", index, 8'h0C);
      cnt = 4;
      while (!last && cnt < 400) begin
         advance = 1'b1; tick(); advance = 1'b0;
         cnt++;
      end
      check("R9 length kept", cnt, 256);
      advance = 1'b1; tick(); advance = 1'b0;
      check("R9 ends", index_valid, 0);
   endtask

   task automatic t_adv_idle();
      for (int i = 0; i < 5; i++) begin
         advance = 1'b1; tick();
      end
      advance = 1'b0;
      check("R10 valid", index_valid, 0);
      check("R10 last", last, 0);
      start = 1'b1; seed = 8'h2A; mode = 1'b0;
      tick();
      start = 1'b0;
      check("R10 first zero", index, 0);
      advance = 1'b1; tick(); advance = 1'b0;
      check("R10 seed next", index, 8'h2A);
      while (index_valid) begin
         advance = 1'b1; tick();
      end
      advance = 1'b0;
   endtask

   initial begin
      t_reset();
      t_full_pass(1'b0, 8'h05);
      t_full_pass(1'b0, 8'h80);
      t_full_pass(1'b1, 8'hA3);
      t_full_pass(1'b1, 8'h00);
      t_start_busy();
      t_adv_idle();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule